// File: doc/BRIEF.md
# Flash Hardware Reset and Ready Sequencer

This block decides how a flash device reacts to its active-low hardware reset pin. The reset input has to stay low for a minimum number of clock cycles before it is accepted. When it is accepted, the block stops any embedded program or erase operation, sends the command state machine back to read-array mode, and starts an internal reset timer. The timer length depends on whether an operation was running at that moment. While the pin is low, the data outputs are tristated and commands are refused. After the pin goes high again, access stays blocked until a recovery count has run out and the internal reset has finished.

The ready/busy output works like an open-drain pin. `rdy_pull_low` high means the line is pulled low (busy). If the reset stopped an operation, the line stays low for the whole long internal reset, however early the pin is released. An aborted operation does not start again by itself: the host must send the command again. A low pulse on the pin that is shorter than the minimum width causes no abort, no state-machine reset, no change to ready/busy and no recovery wait. All delays are clock-count parameters: `MIN_PULSE`, `BUSY_RST_CYC`, `IDLE_RST_CYC` and `RECOVER_CYC`, each at least 1.

Top module: `flash_rst_ctrl`

## Requirements
- R1: Out of system reset, `op_abort` and `sm_reset` are 0, `rdy_pull_low` follows `op_busy`, and `out_en` is 1 while `hw_rst_n` is high.
- R2: A low pulse on `hw_rst_n` is accepted at the clock edge that samples it low for the `MIN_PULSE`-th consecutive time. A shorter pulse is ignored: no `op_abort`, no `sm_reset`, ready/busy unchanged, and `out_en` returns in the same cycle `hw_rst_n` returns high.
- R3: If `op_busy` is 1 at the accepting edge, `op_abort` is 1 for exactly the one cycle after that edge. Otherwise `op_abort` stays 0.
- R4: `sm_reset` is 1 from the accepting edge until the first edge that samples `hw_rst_n` high.
- R5: While `hw_rst_n` is low, `out_en` is 0 and `cmd_ignore` is 1. `cmd_ignore` is always the inverse of `out_en`.
- R6: If `op_busy` was 1 at the accepting edge, `rdy_pull_low` is 1 for `BUSY_RST_CYC` cycles starting after that edge, even if the pin is released earlier.
- R7: If `op_busy` was 0 at the accepting edge, the internal reset lasts `IDLE_RST_CYC` cycles, and the block itself does not pull ready/busy low.
- R8: After an accepted reset, `out_en` returns to 1 only once `hw_rst_n` has been sampled high `RECOVER_CYC` times and the internal reset has finished, whichever comes later.
- R9: The aborted operation does not resume. Once the internal reset ends with `op_busy` at 0, `rdy_pull_low` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sys_rst_n | input | 1 | Asynchronous active-low reset of the sequencer registers |
| hw_rst_n | input | 1 | Hardware reset pin, active low, already synchronised |
| op_busy | input | 1 | Embedded program/erase operation is running |
| op_abort | output | 1 | One-cycle strobe that stops the running operation |
| sm_reset | output | 1 | Holds the command state machine in read-array mode |
| out_en | output | 1 | Data output drivers enabled; 0 means tristate |
| cmd_ignore | output | 1 | Read and write commands are refused |
| rdy_pull_low | output | 1 | Pulls the open-drain ready/busy line low (busy) |

## Verification
A low-width counter that is off by one shows up at the first accepted pulse: `op_abort` and `sm_reset` appear one cycle early or late, or appear at all on a pulse of `MIN_PULSE`-1 cycles. If the operation-state capture is wrong, the internal timer gets the wrong length. That is seen on `rdy_pull_low` at the cycle where the long busy window should end, or as a pull-low that should not be there in the idle case. A wrong recovery count shows on `out_en` within `RECOVER_CYC` cycles after release. The bench compares every output on every cycle of each pulse scenario, so each of these errors is reported in the first cycle where it can be seen.

// File: rtl/flash_rst_ctrl.sv
module flash_rst_ctrl #(
  parameter int MIN_PULSE    = 4,
  parameter int BUSY_RST_CYC = 40,
  parameter int IDLE_RST_CYC = 8,
  parameter int RECOVER_CYC  = 5
) (
  input  logic clk,
  input  logic sys_rst_n,
  input  logic hw_rst_n,
  input  logic op_busy,
  output logic op_abort,
  output logic sm_reset,
  output logic out_en,
  output logic cmd_ignore,
  output logic rdy_pull_low
);
  localparam int MAXC = (BUSY_RST_CYC > IDLE_RST_CYC ? BUSY_RST_CYC : IDLE_RST_CYC) > RECOVER_CYC ?
                        (BUSY_RST_CYC > IDLE_RST_CYC ? BUSY_RST_CYC : IDLE_RST_CYC) : RECOVER_CYC;
  localparam int CW = $clog2(MAXC + 1);
  localparam int LW = $clog2(MIN_PULSE + 1);

  logic [LW-1:0] low_cnt;
  logic [CW-1:0] int_cnt, rec_cnt;
  logic          held, busy_case, abort_q, accept;

  assign accept = !hw_rst_n && (low_cnt == LW'(MIN_PULSE - 1));

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      low_cnt   <= '0;
      held      <= 1'b0;
      busy_case <= 1'b0;
      abort_q   <= 1'b0;
      int_cnt   <= '0;
      rec_cnt   <= '0;
    end else begin
      if (hw_rst_n)                        low_cnt <= '0;
      else if (low_cnt != LW'(MIN_PULSE))  low_cnt <= low_cnt + 1'b1;

      held    <= !hw_rst_n && (held || accept);
      abort_q <= accept && op_busy;

      if (accept) begin
        busy_case <= op_busy;
        int_cnt   <= op_busy ? CW'(BUSY_RST_CYC) : CW'(IDLE_RST_CYC);
      end else if (int_cnt != '0) begin
        int_cnt <= int_cnt - 1'b1;
      end

      if (!hw_rst_n && (held || accept)) rec_cnt <= CW'(RECOVER_CYC);
      else if (rec_cnt != '0)            rec_cnt <= rec_cnt - 1'b1;
    end
  end

  assign op_abort     = abort_q;
  assign sm_reset     = held;
  assign rdy_pull_low = op_busy || (busy_case && (int_cnt != '0));
  assign out_en       = hw_rst_n && (rec_cnt == '0) && (int_cnt == '0);
  assign cmd_ignore   = !out_en;

  // R3
  abort_cause_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    op_abort |-> $past(op_busy) && $past(!hw_rst_n));
  // R3
  abort_single_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    op_abort |=> !op_abort);
  // R6
  abort_busy_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    op_abort |-> rdy_pull_low);
  // R4
  smreset_start_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $rose(sm_reset) |-> $past(!hw_rst_n));
  // R5
  tristate_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    sm_reset |-> !out_en && cmd_ignore);
  // R8
  recover_chk: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $fell(sm_reset) |-> !out_en);
endmodule

// File: tb/flash_rst_ctrl_tb.sv
module flash_rst_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MP = 4, TB = 40, TI = 8, TR = 5;

  logic clk = 1'b0, sys_rst_n = 1'b0, hw_rst_n = 1'b1, op_busy = 1'b0;
  logic op_abort, sm_reset, out_en, cmd_ignore, rdy_pull_low;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_rst_ctrl #(.MIN_PULSE(MP), .BUSY_RST_CYC(TB), .IDLE_RST_CYC(TI), .RECOVER_CYC(TR)) u_dut (
    .clk(clk), .sys_rst_n(sys_rst_n), .hw_rst_n(hw_rst_n), .op_busy(op_busy),
    .op_abort(op_abort), .sm_reset(sm_reset), .out_en(out_en),
    .cmd_ignore(cmd_ignore), .rdy_pull_low(rdy_pull_low));

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic bit exp_abort(int c, int l, bit b);
    return b && (l >= MP) && (c == MP);
  endfunction
  function automatic bit exp_smr(int c, int l);
    return (l >= MP) && (c >= MP) && (c <= l);
  endfunction
  function automatic bit exp_int(int c, int l, bit b);
    int t = b ? TB : TI;
    return (l >= MP) && (c >= MP) && (c <= MP + t - 1);
  endfunction
  function automatic bit exp_oe(int c, int l, bit b);
    int t = b ? TB : TI;
    if (c <= l) return 1'b0;
    if (l < MP) return 1'b1;
    return (c >= l + TR) && (c >= MP + t);
  endfunction

  task automatic run_pulse(input int l, input bit b);
    int n = l + TB + TR + 4;
    @(negedge clk);
    op_busy = b;
    for (int c = 1; c <= n; c++) begin
      @(negedge clk);
      if (op_abort) op_busy = 1'b0;
      hw_rst_n = (c <= l) ? 1'b0 : 1'b1;
      @(posedge clk);
      #(CLK_PERIOD/4);
      chk((l < MP) ? "R2" : "R3", "op_abort", op_abort, exp_abort(c, l, b));
      chk((l < MP) ? "R2" : "R4", "sm_reset", sm_reset, exp_smr(c, l));
      chk(c <= l ? "R5" : "R8", "out_en", out_en, exp_oe(c, l, b));
      chk("R5", "cmd_ignore", cmd_ignore, !exp_oe(c, l, b));
      chk(b ? "R6" : "R7", "rdy_pull_low", rdy_pull_low, op_busy | (b & exp_int(c, l, b)));
    end
    @(negedge clk);
    if (b && l < MP) op_busy = 1'b0;
    @(negedge clk);
    chk("R9", "rdy_pull_low after", rdy_pull_low, 1'b0);
    chk("R9", "out_en after", out_en, 1'b1);
  endtask

  initial begin
    int seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R1", "op_abort rst", op_abort, 1'b0);
    chk("R1", "sm_reset rst", sm_reset, 1'b0);
    chk("R1", "out_en rst", out_en, 1'b1);
    chk("R1", "rdy_pull_low rst", rdy_pull_low, 1'b0);
    sys_rst_n = 1'b1;
    @(negedge clk);
    op_busy = 1'b1;
    #1 chk("R1", "rdy follows busy", rdy_pull_low, 1'b1);
    op_busy = 1'b0;
    run_pulse(1, 1'b1);
    run_pulse(MP - 1, 1'b1);
    run_pulse(MP - 1, 1'b0);
    run_pulse(MP, 1'b1);
    run_pulse(MP, 1'b0);
    run_pulse(MP + 2, 1'b1);
    run_pulse(MP + TB + 10, 1'b1);
    run_pulse(MP + 20, 1'b0);
    for (int i = 0; i < 24; i++) begin
      run_pulse(1 + int'($urandom_range(MP + 45)), 1'($urandom_range(1)));
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 150000; k++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule